// File: doc/BRIEF.md
# Packed SIMD 64-bit ALU

This block is an arithmetic and logic unit that treats one 64-bit word as a set of independent lanes: eight 8-bit lanes, four 16-bit lanes or two 32-bit lanes. One opcode selects the operation and a lane-size code selects the partition. The block covers lane-wise add and subtract with three overflow policies, per-lane shifts, bitwise logic, compares that produce lane masks, a 16-bit lane multiply, and a narrowing pack with signed saturation.

Each cycle the block takes two operands, an opcode, a lane-size code and a shift count, and captures the result in an output register. The result appears one clock later. It suits a media or signal-processing datapath that issues one packed operation per cycle. There is no handshake. A new operation may be presented every cycle.

Top module: `simd_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_o` becomes zero after that edge.
- R2: The result of the inputs present at a rising edge appears on `res_o` after that edge and holds until the next edge, so the latency is one cycle.
- R3: Opcodes on `op_i` are: 0 add, 1 signed-saturating add, 2 unsigned-saturating add, 3 sub, 4 signed-saturating sub, 5 unsigned-saturating sub, 6 shift left logical, 7 shift right logical, 8 shift right arithmetic, 9 AND, 10 AND-NOT, 11 OR, 12 XOR, 13 compare equal, 14 compare greater, 15 16-bit multiply, 16 pack. On `size_i`, 0 selects 8-bit lanes, 1 selects 16-bit lanes, and 2 or 3 selects 32-bit lanes. Lane k occupies bits [k*W +: W]. Opcodes 0 and 3 wrap modulo 2^W in each lane, and no carry or borrow crosses a lane boundary.
- R4: Opcodes 1 and 4 clamp each lane to the signed range [-2^(W-1), 2^(W-1)-1] when the true result leaves that range.
- R5: Opcode 2 clamps each lane to 2^W-1 when the sum overflows. Opcode 5 gives 0 when b exceeds a as unsigned values.
- R6: Shifts move each lane of `a_i` by `shamt_i` (0..63). When the count is at or above W, a logical shift gives 0 and an arithmetic shift fills the lane with its sign bit.
- R7: AND, OR and XOR act on the whole word. AND-NOT gives (~a) & b. `size_i` has no effect on these four operations.
- R8: Compare equal and compare greater set each lane to all ones when the relation holds and to all zeros when it does not. Compare greater treats lane values as signed.
- R9: Opcode 15 multiplies the four 16-bit lanes and keeps the low 16 bits of each product, whatever the values of `size_i` and `shamt_i`.
- R10: With 16-bit lanes, pack converts each 16-bit lane to 8 bits, and with 32-bit lanes it converts each 32-bit lane to 16 bits, using signed saturation. The narrowed lanes of a fill the low half of the result and those of b fill the high half, in lane order. With `size_i` = 0, pack gives zero.
- R11: Opcodes 17 to 31 give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_i | input | 64 | Operand a |
| b_i | input | 64 | Operand b |
| op_i | input | 5 | Operation code |
| size_i | input | 2 | Lane size select |
| shamt_i | input | 6 | Shift count |
| res_o | output | 64 | Registered result |

## Verification
The bench applies the saturation boundaries at lane values 0x7F/0x80 and 0xFF/0x00 in every lane width. A design that let a carry leak between lanes, or that clamped to the wrong limit, would corrupt a neighbouring lane or return a wrapped value. Shift counts equal to the lane width and above it are applied. A design that reduced the count modulo the width would return the operand instead of zero or the sign fill. For signed compare-greater and pack, the bench uses negative lanes. An unsigned comparison would invert the mask, and a missing clamp would keep only the low bits. It also checks that the pack halves come out in the right order, and that the result does not change before the capturing edge.

// File: rtl/simd_pkg.sv
package simd_pkg;
    localparam int DATA_W  = 64;
    localparam int SHAMT_W = 6;
    localparam int OP_W    = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_ADDS  = 5'd1,
        OP_ADDUS = 5'd2,
        OP_SUB   = 5'd3,
        OP_SUBS  = 5'd4,
        OP_SUBUS = 5'd5,
        OP_SLL   = 5'd6,
        OP_SRL   = 5'd7,
        OP_SRA   = 5'd8,
        OP_AND   = 5'd9,
        OP_ANDN  = 5'd10,
        OP_OR    = 5'd11,
        OP_XOR   = 5'd12,
        OP_CMPEQ = 5'd13,
        OP_CMPGT = 5'd14,
        OP_MUL16 = 5'd15,
        OP_PACK  = 5'd16
    } alu_op_e;

    typedef enum logic [1:0] {
        LS_8   = 2'd0,
        LS_16  = 2'd1,
        LS_32  = 2'd2,
        LS_32B = 2'd3
    } lane_sz_e;
endpackage

// File: rtl/simd_lane_unit.sv
module simd_lane_unit
    import simd_pkg::*;
#(
    parameter int DW = 64,
    parameter int LW = 8,
    parameter int CW = 6
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  alu_op_e       op_i,
    input  logic [CW-1:0] shamt_i,
    output logic [DW-1:0] res_o
);
    localparam int NL = DW / LW;
    localparam logic [LW-1:0] SMAX = {1'b0, {(LW-1){1'b1}}};
    localparam logic [LW-1:0] SMIN = {1'b1, {(LW-1){1'b0}}};
    localparam logic [LW-1:0] UMAX = {LW{1'b1}};

    logic shift_over;
    assign shift_over = (int'(shamt_i) >= LW);

    for (genvar g = 0; g < NL; g++) begin : g_lane
        logic [LW-1:0] la, lb, lr;
        logic [LW:0]   sum, dif;
        logic          s_ovf_add, s_ovf_sub;

        assign la  = a_i[g*LW +: LW];
        assign lb  = b_i[g*LW +: LW];
        assign sum = {1'b0, la} + {1'b0, lb};
        assign dif = {1'b0, la} - {1'b0, lb};
        assign s_ovf_add = (la[LW-1] == lb[LW-1]) && (sum[LW-1] != la[LW-1]);
        assign s_ovf_sub = (la[LW-1] != lb[LW-1]) && (dif[LW-1] != la[LW-1]);

        always_comb begin
            lr = '0;
            case (op_i)
                OP_ADD:   lr = sum[LW-1:0];
                OP_ADDS:  lr = s_ovf_add ? (la[LW-1] ? SMIN : SMAX) : sum[LW-1:0];
                OP_ADDUS: lr = sum[LW] ? UMAX : sum[LW-1:0];
                OP_SUB:   lr = dif[LW-1:0];
                OP_SUBS:  lr = s_ovf_sub ? (la[LW-1] ? SMIN : SMAX) : dif[LW-1:0];
                OP_SUBUS: lr = dif[LW] ? '0 : dif[LW-1:0];
                OP_SLL:   lr = shift_over ? '0 : (la << shamt_i);
                OP_SRL:   lr = shift_over ? '0 : (la >> shamt_i);
                OP_SRA:   lr = shift_over ? {LW{la[LW-1]}}
                                          : LW'($signed(la) >>> shamt_i);
                OP_CMPEQ: lr = {LW{la == lb}};
                OP_CMPGT: lr = {LW{$signed(la) > $signed(lb)}};
                default:  lr = '0;
            endcase
        end

        assign res_o[g*LW +: LW] = lr;
    end
endmodule

// File: rtl/simd_mul16.sv
module simd_mul16 #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] res_o
);
    localparam int LW = 16;
    localparam int NL = DW / LW;

    for (genvar g = 0; g < NL; g++) begin : g_mul
        logic [2*LW-1:0] prod;
        assign prod = {{LW{1'b0}}, a_i[g*LW +: LW]} * {{LW{1'b0}}, b_i[g*LW +: LW]};
        assign res_o[g*LW +: LW] = prod[LW-1:0];
    end
endmodule

// File: rtl/simd_pack.sv
module simd_pack #(
    parameter int DW = 64,
    parameter int WW = 16
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] res_o
);
    localparam int NW = WW / 2;
    localparam int NS = DW / WW;
    localparam int TW = WW - NW + 1;

    function automatic logic [NW-1:0] narrow(input logic [WW-1:0] v);
        logic [TW-1:0] top;
        top = v[WW-1:NW-1];
        if ((&top) || !(|top)) return v[NW-1:0];
        return v[WW-1] ? {1'b1, {(NW-1){1'b0}}} : {1'b0, {(NW-1){1'b1}}};
    endfunction

    for (genvar g = 0; g < NS; g++) begin : g_pk
        assign res_o[g*NW +: NW]      = narrow(a_i[g*WW +: WW]);
        assign res_o[(NS+g)*NW +: NW] = narrow(b_i[g*WW +: WW]);
    end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = SHAMT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DW-1:0]     a_i,
    input  logic [DW-1:0]     b_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [1:0]        size_i,
    input  logic [CW-1:0]     shamt_i,
    output logic [DW-1:0]     res_o
);
    localparam int NWID = 3;
    localparam int WID [NWID] = '{8, 16, 32};

    alu_op_e  op;
    lane_sz_e sz;
    assign op = alu_op_e'(op_i);
    assign sz = lane_sz_e'(size_i);

    logic [DW-1:0] lane_res [NWID];
    logic [DW-1:0] mul_res, pack16_res, pack32_res;
    logic [DW-1:0] nxt_res;

    for (genvar w = 0; w < NWID; w++) begin : g_width
        simd_lane_unit #(.DW(DW), .LW(WID[w]), .CW(CW)) u_lanes (
            .a_i     (a_i),
            .b_i     (b_i),
            .op_i    (op),
            .shamt_i (shamt_i),
            .res_o   (lane_res[w])
        );
    end

    simd_mul16 #(.DW(DW)) u_mul (
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (mul_res)
    );

    simd_pack #(.DW(DW), .WW(16)) u_pack16 (
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (pack16_res)
    );

    simd_pack #(.DW(DW), .WW(32)) u_pack32 (
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (pack32_res)
    );

    always_comb begin
        nxt_res = '0;
        case (op)
            OP_AND:   nxt_res = a_i & b_i;
            OP_ANDN:  nxt_res = ~a_i & b_i;
            OP_OR:    nxt_res = a_i | b_i;
            OP_XOR:   nxt_res = a_i ^ b_i;
            OP_MUL16: nxt_res = mul_res;
            OP_PACK: begin
                unique case (sz)
                    LS_8:          nxt_res = '0;
                    LS_16:         nxt_res = pack16_res;
                    LS_32, LS_32B: nxt_res = pack32_res;
                endcase
            end
            OP_ADD, OP_ADDS, OP_ADDUS, OP_SUB, OP_SUBS, OP_SUBUS,
            OP_SLL, OP_SRL, OP_SRA, OP_CMPEQ, OP_CMPGT: begin
                unique case (sz)
                    LS_8:          nxt_res = lane_res[0];
                    LS_16:         nxt_res = lane_res[1];
                    LS_32, LS_32B: nxt_res = lane_res[2];
                endcase
            end
            default:  nxt_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) res_o <= '0;
        else     res_o <= nxt_res;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (res_o == '0)); // R1

    AST_XOR_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_XOR) |=> (res_o == ($past(a_i) ^ $past(b_i)))); // R2

    AST_USAT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_ADDUS && size_i == LS_8) |=> (res_o[7:0] >= $past(a_i[7:0]))); // R5

    AST_SRL_OVER: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SRL && int'(shamt_i) >= 32 && size_i[1]) |=> (res_o == '0)); // R6

    AST_CMP_MASK: assert property (@(posedge clk) disable iff (rst)
        ((op_i == OP_CMPEQ || op_i == OP_CMPGT) && size_i == LS_16)
        |=> ((res_o[15:0] == '0 || res_o[15:0] == '1) &&
             (res_o[63:48] == '0 || res_o[63:48] == '1))); // R8

    AST_UNUSED_OP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_i > OP_PACK) |=> (res_o == '0)); // R11
endmodule

// File: tb/simd_alu_tb.sv
module simd_alu_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] a, b;
    logic [4:0]  op;
    logic [1:0]  sz;
    logic [5:0]  sh;
    logic [63:0] res;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    simd_alu u_dut (
        .clk(clk), .rst(rst), .a_i(a), .b_i(b), .op_i(op),
        .size_i(sz), .shamt_i(sh), .res_o(res)
    );

    function automatic longint sx(longint u, int w);
        return (u >= (64'sd1 <<< (w-1))) ? u - (64'sd1 <<< w) : u;
    endfunction

    function automatic longint clampl(longint v, longint lo, longint hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic logic [63:0] model(logic [63:0] ia, logic [63:0] ib,
                                         int iop, int isz, int ish);
        logic [63:0] r = '0;
        int w = (isz == 0) ? 8 : ((isz == 1) ? 16 : 32);
        longint m, ua, ub, sa, sb, v;
        if (iop == 9)  return ia & ib;
        if (iop == 10) return ~ia & ib;
        if (iop == 11) return ia | ib;
        if (iop == 12) return ia ^ ib;
        if (iop > 16)  return '0;
        if (iop == 15) w = 16;
        if (iop == 16) begin
            int nw, ns;
            if (isz == 0) return '0;
            nw = w / 2;
            ns = 64 / w;
            m  = (64'sd1 <<< nw) - 1;
            for (int j = 0; j < 2*ns; j++) begin
                ua = longint'(((j < ns) ? ia : ib) >> (((j < ns) ? j : j-ns)*w)) & ((64'sd1 <<< w) - 1);
                v  = clampl(sx(ua, w), -(64'sd1 <<< (nw-1)), (64'sd1 <<< (nw-1)) - 1);
                r  = r | (64'(v & m) << (j*nw));
            end
            return r;
        end
        m = (64'sd1 <<< w) - 1;
        for (int l = 0; l < 64/w; l++) begin
            ua = longint'(ia >> (l*w)) & m;
            ub = longint'(ib >> (l*w)) & m;
            sa = sx(ua, w);
            sb = sx(ub, w);
            case (iop)
                0:  v = ua + ub;
                1:  v = clampl(sa + sb, -(64'sd1 <<< (w-1)), (64'sd1 <<< (w-1)) - 1);
                2:  v = clampl(ua + ub, 0, m);
                3:  v = ua - ub;
                4:  v = clampl(sa - sb, -(64'sd1 <<< (w-1)), (64'sd1 <<< (w-1)) - 1);
                5:  v = clampl(ua - ub, 0, m);
                6:  v = (ish >= w) ? 0 : (ua <<< ish);
                7:  v = (ish >= w) ? 0 : (ua >>> ish);
                8:  v = (ish >= w) ? ((sa < 0) ? -1 : 0) : (sa >>> ish);
                13: v = (ua == ub) ? -1 : 0;
                14: v = (sa > sb) ? -1 : 0;
                15: v = ua * ub;
                default: v = 0;
            endcase
            r = r | (64'(v & m) << (l*w));
        end
        return r;
    endfunction

    function automatic string req_of(int iop);
        if (iop == 0 || iop == 3) return "R3";
        if (iop == 1 || iop == 4) return "R4";
        if (iop == 2 || iop == 5) return "R5";
        if (iop >= 6 && iop <= 8) return "R6";
        if (iop >= 9 && iop <= 12) return "R7";
        if (iop == 13 || iop == 14) return "R8";
        if (iop == 15) return "R9";
        if (iop == 16) return "R10";
        return "R11";
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run(logic [63:0] ia, logic [63:0] ib, int iop, int isz, int ish);
        logic [63:0] exp;
        @(negedge clk);
        a = ia; b = ib; op = 5'(iop); sz = 2'(isz); sh = 6'(ish);
        exp = model(ia, ib, iop, isz, ish);
        @(posedge clk);
        @(negedge clk);
        check(req_of(iop), res, exp);
    endtask

    function automatic logic [63:0] corner();
        logic [63:0] v;
        for (int k = 0; k < 8; k++) begin
            case ($urandom % 6)
                0: v[k*8 +: 8] = 8'h7F;
                1: v[k*8 +: 8] = 8'h80;
                2: v[k*8 +: 8] = 8'hFF;
                3: v[k*8 +: 8] = 8'h00;
                default: v[k*8 +: 8] = 8'($urandom);
            endcase
        end
        return v;
    endfunction

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'd4242));
        rst = 1'b1; a = '1; b = '1; op = 5'd0; sz = 2'd0; sh = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", res, 64'h0);
        rst = 1'b0;

        // R3 no carry across lanes: 0xFF+0x01 per byte
        run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 0, 0, 0);
        run(64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 0, 1, 0);
        run(64'h0000_0000_0000_0000, 64'h0000_0001_0000_0001, 3, 2, 0);
        // R4 signed saturation at 7F/80
        run(64'h7F80_7F80_7F80_7F80, 64'h0180_0180_0180_0180, 1, 0, 0);
        run(64'h8000_7FFF_8000_7FFF, 64'h0001_FFFF_0001_0001, 4, 1, 0);
        run(64'h8000_0000_7FFF_FFFF, 64'h0000_0001_0000_0001, 1, 2, 0);
        // R5 unsigned saturation
        run(64'hFF01_FF01_FF01_FF01, 64'h0102_0102_0102_0102, 2, 0, 0);
        run(64'h0001_0001_0001_0005, 64'h0002_0001_0002_0003, 5, 1, 0);
        // R6 shift counts at and above lane width
        run(64'h8123_4567_89AB_CDEF, 64'h0, 8, 0, 8);
        run(64'h8123_4567_89AB_CDEF, 64'h0, 7, 1, 16);
        run(64'h8123_4567_89AB_CDEF, 64'h0, 6, 2, 31);
        run(64'h8123_4567_89AB_CDEF, 64'h0, 8, 2, 40);
        run(64'h8123_4567_89AB_CDEF, 64'h0, 8, 1, 3);
        // R7 size has no effect on bitwise ops
        run(64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_AAAA, 10, 0, 5);
        run(64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_AAAA, 10, 3, 5);
        // R8 signed greater, equality masks
        run(64'h80FF_0102_7F00_0000, 64'h7F00_0101_8001_0000, 14, 0, 0);
        run(64'h1234_5678_9ABC_DEF0, 64'h1234_0000_9ABC_0000, 13, 1, 0);
        // R9 multiply low halves, size and shift ignored
        run(64'hFFFF_0100_0003_8000, 64'hFFFF_0100_0005_0002, 15, 0, 17);
        // R10 pack order and saturation
        run(64'h8000_007F_0080_FF80, 64'h7FFF_0001_FFFF_0100, 16, 1, 0);
        run(64'h8000_0000_0000_7FFF, 64'hFFFF_8000_0001_0000, 16, 2, 0);
        run(64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 16, 0, 0);
        // R11 undefined opcodes, size code 3 behaves as 32-bit lanes
        run(64'hDEAD_BEEF_DEAD_BEEF, 64'h1, 23, 1, 0);
        run(64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 0, 3, 0);

        // R2 output holds until capturing edge
        run(64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, 12, 0, 0);
        held = res;
        @(negedge clk);
        a = '0; b = '0; op = 5'd11;
        #5;
        check("R2", res, held);
        @(posedge clk);
        @(negedge clk);
        check("R2", res, 64'h0);

        for (int i = 0; i < 600; i++) begin
            logic [63:0] ra, rb;
            int rsh;
            ra  = ($urandom % 2) ? corner() : {$urandom, $urandom};
            rb  = ($urandom % 2) ? corner() : {$urandom, $urandom};
            rsh = ($urandom % 2) ? int'($urandom % 10) : int'($urandom % 64);
            run(ra, rb, int'($urandom % 20), int'($urandom % 4), rsh);
        end

        // R1 reset mid-stream clears result
        @(negedge clk);
        a = '1; b = '1; op = 5'd11; rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", res, 64'h0);
        rst = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule